// File: doc/BRIEF.md
# Sine Test-Tone Generator with Sync

This block produces the digital sample stream for a test-signal converter. It runs from a master clock that is nominally 4.096 MHz. It emits one signed sample, with a one-cycle valid strobe, every `SAMPLE_DIV` clocks. In sine mode a phase accumulator advances by a step built from two 8-bit frequency codes. A folded quarter-wave table turns the top phase bits into a sine value. A logarithmic gain code then scales that value in half-decibel steps, and the top codes mute the output.

A synchronisation input lines the waveform up with an external sampling grid. Its rising edge, taken through a synchroniser, restarts the phase at the zero crossing. A steady level on this input has no effect in sine mode, and neither does a falling edge. The same input chooses between two levels when the block is in pulse mode. A fixed DC level is also available.

Top module: `tone_synth`

## Requirements
- R1: `valid_o` is high for exactly one cycle out of every `SAMPLE_DIV` (default 16) clock cycles. `sample_o` changes only together with a valid pulse.
- R2: The phase step is min(M·2^N, `MAX_STEP`), where M is `freq_m_i` and N is `freq_n_i`. The default `MAX_STEP` is 512, which with a 19-bit accumulator gives 250 Hz at a 256 kHz sample rate. The step is 0 when M is 0. The accumulator wraps modulo 2^19 and advances once per sample, and the first sample after reset holds one step of phase.
- R3: In sine mode (`mode_i` = 0) the unscaled sample is round(32767·sin(2π·P/1024)), where P is the top 10 bits of the accumulator (bits 18..9).
- R4: Gain code c in the range 0..239 multiplies the sine by 10^(−c/40), so code 0 is unity. Codes 240..255 force the sine sample to 0.
- R5: After a rising edge on `sync_i`, the next accumulator update loads 0 instead of adding the step, so the sample that follows is 0.
- R6: In sine mode, holding `sync_i` high or low, and a falling edge on it, leave the phase progression unchanged.
- R7: In DC mode (`mode_i` = 1) the sample equals `dc_level_i`, and the gain code does not apply.
- R8: In pulse mode (`mode_i` = 2) the sample is `pulse_lo_i` while the synchronised `sync_i` is low and `pulse_hi_i` while it is high.
- R9: `mode_i` = 3 is an idle mode in which the sample is 0.
- R10: While `rst_n` is low, `sample_o` is 0 and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 sine, 1 DC, 2 pulse, 3 idle |
| freq_m_i | input | 8 | Frequency multiplier code M |
| freq_n_i | input | 8 | Frequency shift code N |
| gain_code_i | input | 8 | Attenuation in 0.5 dB steps; 240 and above mute |
| dc_level_i | input | 16 | Signed DC output level |
| pulse_lo_i | input | 16 | Signed pulse level chosen when sync is low |
| pulse_hi_i | input | 16 | Signed pulse level chosen when sync is high |
| sync_i | input | 1 | Asynchronous synchronisation input |
| sample_o | output | 16 | Signed output sample |
| valid_o | output | 1 | One-cycle strobe per sample |

## Verification
The bench drives the frequency codes so that the step saturates in two ways, from a large M and from a shift count larger than the accumulator. A design that clamped wrongly, or let the shift overflow, would step the phase far too fast and miss the expected sine values. Each sync is raised between two samples and then dropped while tones are running. A design that reset on the level or on the falling edge would stall or restart the phase, and one that reset on the wrong tick would show no zero sample. The bench also checks the boundary between gain codes 239 and 240, DC output with a mute code present, both pulse levels and the idle mode.

// File: rtl/tone_pkg.sv
`timescale 1ns/1ps
package tone_pkg;
   typedef enum logic [1:0] {
      TM_SINE  = 2'd0,
      TM_DC    = 2'd1,
      TM_PULSE = 2'd2,
      TM_IDLE  = 2'd3
   } tone_mode_e;

   localparam real TONE_PI = 3.14159265358979323846;
endpackage

// File: rtl/tone_tick.sv
`timescale 1ns/1ps
// Sample-rate strobe: one cycle high every DIV clocks.
module tone_tick #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV < 2) begin : g_bad_div
      $error("tone_tick: DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (cnt == CW'(DIV - 1)) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tick_o = (cnt == CW'(DIV - 1));
endmodule

// File: rtl/tone_phase.sv
`timescale 1ns/1ps
// Phase accumulator with saturating M*2^N step and sync-edge restart.
module tone_phase #(
   parameter int ACC_W       = 19,
   parameter int MAX_STEP    = 512,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             sync_i,
   input  logic [7:0]       m_i,
   input  logic [7:0]       n_i,
   output logic [ACC_W-1:0] phase_o,
   output logic             sync_lvl_o
);
   localparam int WIDE = ACC_W + 8;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tone_phase: SYNC_STAGES must be at least 2");
   end
   if (MAX_STEP < 1 || MAX_STEP >= (1 << (ACC_W - 1))) begin : g_bad_step
      $error("tone_phase: MAX_STEP out of range for ACC_W");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic                   sync_prev;
   logic                   rise;
   logic                   pend;
   logic [WIDE-1:0]        shifted;
   logic [ACC_W-1:0]       step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain     <= '0;
         sync_prev <= 1'b0;
      end else begin
         chain     <= {chain[SYNC_STAGES-2:0], sync_i};
         sync_prev <= chain[SYNC_STAGES-1];
      end
   end

   assign rise       = chain[SYNC_STAGES-1] & ~sync_prev;
   assign sync_lvl_o = chain[SYNC_STAGES-1];

   always_comb begin
      shifted = WIDE'(m_i) << n_i;
      if (m_i == 8'd0) begin
         step = '0;
      end else if ((n_i >= 8'(ACC_W)) || (shifted > WIDE'(MAX_STEP))) begin
         step = ACC_W'(MAX_STEP);
      end else begin
         step = shifted[ACC_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_o <= '0;
         pend    <= 1'b0;
      end else if (tick_i) begin
         pend    <= 1'b0;
         phase_o <= (rise || pend) ? '0 : phase_o + step;
      end else if (rise) begin
         pend    <= 1'b1;
      end
   end
endmodule

// File: rtl/tone_wave.sv
`timescale 1ns/1ps
// Quarter-wave sine table with symmetry folding.
module tone_wave
   import tone_pkg::*;
#(
   parameter int ACC_W = 19,
   parameter int LUT_W = 8,
   parameter int AMP_W = 16
) (
   input  logic [ACC_W-1:0]        phase_i,
   output logic signed [AMP_W-1:0] sine_o
);
   localparam int Q = 1 << LUT_W;

   if (ACC_W < LUT_W + 2) begin : g_bad_acc
      $error("tone_wave: ACC_W must exceed LUT_W by at least 2");
   end

   function automatic int sine_entry(input int k);
      real a;
      a = (2.0 ** (AMP_W - 1) - 1.0) * $sin(TONE_PI / 2.0 * k / Q);
      return $rtoi(a + 0.5);
   endfunction

   logic signed [AMP_W-1:0] tbl [0:Q];

   for (genvar g = 0; g <= Q; g++) begin : g_tbl
      assign tbl[g] = AMP_W'(sine_entry(g));
   end

   logic [1:0]       quad;
   logic [LUT_W-1:0] idx;
   logic [LUT_W:0]   addr;
   logic signed [AMP_W-1:0] mag;

   assign quad = phase_i[ACC_W-1 -: 2];
   assign idx  = phase_i[ACC_W-3 -: LUT_W];

   always_comb begin
      addr   = quad[0] ? ((LUT_W+1)'(Q) - {1'b0, idx}) : {1'b0, idx};
      mag    = tbl[addr];
      sine_o = quad[1] ? -mag : mag;
   end
endmodule

// File: rtl/tone_gain.sv
`timescale 1ns/1ps
// Logarithmic half-decibel gain with a mute range at the top of the code space.
module tone_gain #(
   parameter int AMP_W     = 16,
   parameter int GAIN_W    = 18,
   parameter int MUTE_FROM = 240
) (
   input  logic signed [AMP_W-1:0] sine_i,
   input  logic [7:0]              code_i,
   output logic signed [AMP_W-1:0] sample_o
);
   localparam int PW = AMP_W + GAIN_W + 1;

   if (MUTE_FROM < 1 || MUTE_FROM > 256) begin : g_bad_mute
      $error("tone_gain: MUTE_FROM must lie in 1..256");
   end

   function automatic int gain_entry(input int c);
      real g;
      g = (2.0 ** (GAIN_W - 1)) * (10.0 ** (-c / 40.0));
      return $rtoi(g + 0.5);
   endfunction

   logic [GAIN_W-1:0] lut [0:MUTE_FROM-1];

   for (genvar c = 0; c < MUTE_FROM; c++) begin : g_lut
      assign lut[c] = GAIN_W'(gain_entry(c));
   end

   logic              mute;
   logic [GAIN_W-1:0] gain;
   logic signed [PW-1:0] prod;

   always_comb begin
      mute     = (32'(code_i) >= MUTE_FROM);
      gain     = mute ? '0 : lut[mute ? 8'd0 : code_i];
      prod     = PW'($signed({1'b0, gain})) * PW'(sine_i);
      sample_o = mute ? '0 : AMP_W'(prod >>> (GAIN_W - 1));
   end
endmodule

// File: rtl/tone_synth.sv
`timescale 1ns/1ps
// Top: sample tick, phase, sine, gain and the mode output register.
module tone_synth
   import tone_pkg::*;
#(
   parameter int SAMPLE_DIV  = 16,
   parameter int ACC_W       = 19,
   parameter int LUT_W       = 8,
   parameter int AMP_W       = 16,
   parameter int GAIN_W      = 18,
   parameter int MUTE_FROM   = 240,
   parameter int MAX_STEP    = 512,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic [7:0]        freq_m_i,
   input  logic [7:0]        freq_n_i,
   input  logic [7:0]        gain_code_i,
   input  logic [AMP_W-1:0]  dc_level_i,
   input  logic [AMP_W-1:0]  pulse_lo_i,
   input  logic [AMP_W-1:0]  pulse_hi_i,
   input  logic              sync_i,
   output logic [AMP_W-1:0]  sample_o,
   output logic              valid_o
);
   logic                    tick;
   logic                    tick_q;
   logic [ACC_W-1:0]        phase;
   logic                    sync_lvl;
   logic signed [AMP_W-1:0] sine;
   logic signed [AMP_W-1:0] scaled;
   tone_mode_e              mode;

   tone_tick #(.DIV(SAMPLE_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   tone_phase #(
      .ACC_W       (ACC_W),
      .MAX_STEP    (MAX_STEP),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .sync_i     (sync_i),
      .m_i        (freq_m_i),
      .n_i        (freq_n_i),
      .phase_o    (phase),
      .sync_lvl_o (sync_lvl)
   );

   tone_wave #(
      .ACC_W (ACC_W),
      .LUT_W (LUT_W),
      .AMP_W (AMP_W)
   ) u_wave (
      .phase_i (phase),
      .sine_o  (sine)
   );

   tone_gain #(
      .AMP_W     (AMP_W),
      .GAIN_W    (GAIN_W),
      .MUTE_FROM (MUTE_FROM)
   ) u_gain (
      .sine_i   (sine),
      .code_i   (gain_code_i),
      .sample_o (scaled)
   );

   assign mode = tone_mode_e'(mode_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q   <= 1'b0;
         valid_o  <= 1'b0;
         sample_o <= '0;
      end else begin
         tick_q  <= tick;
         valid_o <= tick_q;
         if (tick_q) begin
            case (mode)
               TM_SINE:  sample_o <= scaled;
               TM_DC:    sample_o <= dc_level_i;
               TM_PULSE: sample_o <= sync_lvl ? pulse_hi_i : pulse_lo_i;
               default:  sample_o <= '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/tone_synth_chk.sv
`timescale 1ns/1ps
module tone_synth_chk #(
   parameter int DIV       = 16,
   parameter int AMP_W     = 16,
   parameter int MUTE_FROM = 240
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_i,
   input logic [7:0]       gain_code_i,
   input logic [AMP_W-1:0] dc_level_i,
   input logic [AMP_W-1:0] sample_o,
   input logic             valid_o
);
   logic [15:0] gap;
   logic        seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (valid_o) begin
         gap  <= 16'd1;
         seen <= 1'b1;
      end else if (gap != 16'hFFFF) begin
         gap <= gap + 16'd1;
      end
   end

   // R1: strobes are spaced exactly DIV cycles apart
   a_r1_period: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && seen) |-> (gap == 16'(DIV)));

   // R1: the sample only changes together with a strobe
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(sample_o));

   // R4: mute codes give a zero sine sample
   a_r4_mute: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(mode_i) == 2'd0 && 32'($past(gain_code_i)) >= MUTE_FROM)
      |-> (sample_o == '0));

   // R7: DC mode passes the level through
   a_r7_dc: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(mode_i) == 2'd1) |-> (sample_o == $past(dc_level_i)));

   // R9: idle mode outputs zero
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(mode_i) == 2'd3) |-> (sample_o == '0));
endmodule

bind tone_synth tone_synth_chk #(
   .DIV       (SAMPLE_DIV),
   .AMP_W     (AMP_W),
   .MUTE_FROM (MUTE_FROM)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_i      (mode_i),
   .gain_code_i (gain_code_i),
   .dc_level_i  (dc_level_i),
   .sample_o    (sample_o),
   .valid_o     (valid_o)
);

// File: tb/tone_synth_tb.sv
`timescale 1ns/1ps
module tone_synth_tb;
   localparam real PI = 3.14159265358979323846;
   // {M, N, gain code, expected step}
   localparam int NV = 8;
   localparam logic [35:0] VEC [NV] = '{
      {8'd1,   8'd9,  8'd0,   12'd512},
      {8'd255, 8'd7,  8'd0,   12'd512},
      {8'd5,   8'd6,  8'd12,  12'd320},
      {8'd200, 8'd0,  8'd0,   12'd200},
      {8'd3,   8'd30, 8'd40,  12'd512},
      {8'd7,   8'd5,  8'd239, 12'd224},
      {8'd9,   8'd5,  8'd240, 12'd288},
      {8'd0,   8'd3,  8'd0,   12'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_i = 2'd0;
   logic [7:0]  freq_m_i = 8'd0;
   logic [7:0]  freq_n_i = 8'd0;
   logic [7:0]  gain_code_i = 8'd0;
   logic [15:0] dc_level_i = 16'd0;
   logic [15:0] pulse_lo_i = 16'd0;
   logic [15:0] pulse_hi_i = 16'd0;
   logic        sync_i = 1'b0;
   logic [15:0] sample_o;
   logic        valid_o;

   int total = 0;
   int fails = 0;

   always #2 clk = ~clk;

   tone_synth u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode_i),
      .freq_m_i    (freq_m_i),
      .freq_n_i    (freq_n_i),
      .gain_code_i (gain_code_i),
      .dc_level_i  (dc_level_i),
      .pulse_lo_i  (pulse_lo_i),
      .pulse_hi_i  (pulse_hi_i),
      .sync_i      (sync_i),
      .sample_o    (sample_o),
      .valid_o     (valid_o)
   );

   task automatic chk(input string req, input int act, input int exp, input int tol);
      int d;
      total++;
      d = act - exp;
      if (d < 0) d = -d;
      if (d > tol) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_valid();
      @(negedge clk);
      while (!valid_o) @(negedge clk);
   endtask

   function automatic int model_sine(input int acc, input int code);
      int  p;
      real s;
      if (code >= 240) return 0;
      p = (acc >> 9) & 1023;
      s = 32767.0 * $sin(2.0 * PI * p / 1024.0) * (10.0 ** (-code / 40.0));
      return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
   endfunction

   function automatic int sval();
      return int'($signed(sample_o));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int gap;
      // R10: reset state
      repeat (5) @(negedge clk);
      chk("R10 valid in reset", int'(valid_o), 0, 0);
      chk("R10 sample in reset", sval(), 0, 0);
      freq_m_i = 8'd1;
      freq_n_i = 8'd9;
      @(negedge clk);
      rst_n = 1'b1;

      // R2: first sample after reset holds one step (512 -> P=1)
      wait_valid();
      chk("R2 first sample", sval(), model_sine(512, 0), 1);

      // R1: strobe period
      gap = 0;
      @(negedge clk);
      gap++;
      while (!valid_o) begin
         @(negedge clk);
         gap++;
      end
      chk("R1 period", gap, 16, 0);

      // R2 R3 R4 R5 R6: vector walk
      for (int v = 0; v < NV; v++) begin
         int step;
         int code;
         freq_m_i    = VEC[v][35:28];
         freq_n_i    = VEC[v][27:20];
         gain_code_i = VEC[v][19:12];
         step        = int'(VEC[v][11:0]);
         code        = int'(VEC[v][19:12]);
         mode_i      = 2'd0;
         wait_valid();
         sync_i = 1'b1;
         wait_valid();
         chk("R5 zero after sync rise", sval(), 0, 0);
         for (int k = 1; k <= 8; k++) begin
            wait_valid();
            chk("R3/R4 sine sample (R2 step)", sval(),
                model_sine((k * step) & 32'h7FFFF, code), 2);
            if (k == 3) sync_i = 1'b0; // R6: falling edge must not restart
         end
      end

      // R6: long run with sync held low keeps advancing
      freq_m_i    = 8'd1;
      freq_n_i    = 8'd9;
      gain_code_i = 8'd0;
      wait_valid();
      sync_i = 1'b1;
      wait_valid();
      for (int k = 1; k <= 300; k++) begin
         wait_valid();
         if (k == 40) sync_i = 1'b0;
         if (k % 50 == 0)
            chk("R6 phase continues", sval(), model_sine((k * 512) & 32'h7FFFF, 0), 1);
      end

      // R7: DC mode ignores gain
      mode_i      = 2'd1;
      gain_code_i = 8'd255;
      dc_level_i  = 16'hCFC7; // -12345
      wait_valid();
      wait_valid();
      chk("R7 dc level", sval(), -12345, 0);
      dc_level_i = 16'd32767;
      wait_valid();
      wait_valid();
      chk("R7 dc max", sval(), 32767, 0);

      // R8: pulse levels
      mode_i     = 2'd2;
      pulse_lo_i = 16'd1111;
      pulse_hi_i = 16'hF752; // -2222
      sync_i     = 1'b0;
      wait_valid();
      wait_valid();
      chk("R8 pulse low level", sval(), 1111, 0);
      sync_i = 1'b1;
      wait_valid();
      wait_valid();
      chk("R8 pulse high level", sval(), -2222, 0);
      sync_i = 1'b0;
      wait_valid();
      wait_valid();
      chk("R8 pulse back low", sval(), 1111, 0);

      // R9: idle mode
      mode_i = 2'd3;
      wait_valid();
      wait_valid();
      chk("R9 idle zero", sval(), 0, 0);

      // R10: reset reasserted mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 valid after reset", int'(valid_o), 0, 0);
      chk("R10 sample after reset", sval(), 0, 0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule